// File: doc/BRIEF.md
# Arithmetic Logic Unit with Status Flag Word

A 16-bit combinational arithmetic logic unit paired with a clocked status flag word. Two operands, a 3-bit operation code and a byte/word select produce a result in the same cycle. The unit performs addition, subtraction, bitwise AND, OR and XOR, increment and decrement. Alongside the result it derives six condition flags: carry, auxiliary carry, parity, zero, sign and overflow.

The flag word is a 16-bit register. When the condition write enable is high, the clock edge captures the condition flags of the current operation. A separate load port sets the three control flags: single-step trap, interrupt enable and string direction. The two write paths are independent, so both can act on the same edge. The flag word sits beside an execution datapath, so a later conditional step can read the outcome of the last operation.

Top module: `alu_flag_unit`

## Requirements
- R1: The operation codes are 0 add, 1 subtract (a-b), 2 AND, 3 OR, 4 XOR, 5 increment (a+1) and 6 decrement (a-1). In word mode (byte_i=0) the result is the 16-bit value modulo 2^16. In byte mode (byte_i=1) only the low bytes are used: result bits 7:0 hold the 8-bit value and bits 15:8 are zero.
- R2: Carry (flag bit 0) is captured as the carry out of the top bit of the active width for add, or the borrow for subtract. The top bit is bit 15 in word mode and bit 7 in byte mode.
- R3: Auxiliary carry (flag bit 4) is captured as the carry (add, increment) or borrow (subtract, decrement) from bit 3 into bit 4. It is zero after a logical operation.
- R4: Parity (flag bit 2) is 1 when result bits 7:0 hold an even number of ones, and 0 when they hold an odd number, in either width.
- R5: Zero (flag bit 6) is 1 exactly when the result is zero. Sign (flag bit 7) equals the top bit of the active width of the result.
- R6: Overflow (flag bit 11) is 1 when add, subtract, increment or decrement gives a two's-complement result outside the signed range of the active width.
- R7: AND, OR and XOR clear carry, overflow and auxiliary carry.
- R8: Increment and decrement update every condition flag except carry, which keeps its previous value.
- R9: Condition flags change only on a clock edge with flag_we_i=1. A condition update never alters the control flags.
- R10: When ctl_we_i=1, the clock edge loads trap (bit 8), interrupt enable (bit 9) and direction (bit 10) from ctl_i[0], ctl_i[1] and ctl_i[2]. Bits 1, 3, 5 and 12 to 15 always read as zero.
- R11: An active-low reset clears the whole flag word to zero.
- R12: Operation code 7 is reserved. It gives a zero result and leaves the flag word unchanged even with flag_we_i=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand (unused by increment and decrement) |
| op_i | input | 3 | Operation code |
| byte_i | input | 1 | 1 selects 8-bit operation on the low bytes |
| flag_we_i | input | 1 | Capture the condition flags on this edge |
| ctl_we_i | input | 1 | Load the control flags on this edge |
| ctl_i | input | 3 | Control flag values {direction, interrupt, trap} |
| result_o | output | 16 | Combinational result |
| flags_o | output | 16 | Registered flag word |

## Verification
The operand pairs are chosen to separate the flag conditions from one another:
- Carry out without signed overflow, and signed overflow without carry out.
- Both together on 0x8000+0x8000.
- A borrow through the nibble boundary against one that stays inside it.
- Byte-mode cases whose upper operand bytes would change carry, sign or zero if the width select were ignored.

Increment and decrement run both after an operation that sets carry and after one that clears it, which shows whether carry is kept. Directed cases toggle each write enable alone and use the reserved code, to show that nothing else moves the flag word.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_INC = 3'd5,
    OP_DEC = 3'd6,
    OP_RSV = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic af_f;
    logic pf_f;
    logic cf_f;
  } cond_flags_t;

  localparam int FLAG_W = 16;
  localparam int CF_POS = 0;
  localparam int PF_POS = 2;
  localparam int AF_POS = 4;
  localparam int ZF_POS = 6;
  localparam int SF_POS = 7;
  localparam int TF_POS = 8;
  localparam int IF_POS = 9;
  localparam int DF_POS = 10;
  localparam int OF_POS = 11;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         byte_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         aux_o,
  output logic         ovf_o
);
  localparam int H = W / 2;

  logic [W-1:0] y;
  logic [W:0]   s;
  logic [W-1:0] cin_vec;
  logic         cy_raw;

  always_comb begin
    y       = sub_i ? ~b_i : b_i;
    s       = {1'b0, a_i} + {1'b0, y} + (W+1)'(sub_i);
    cin_vec = a_i ^ y ^ s[W-1:0];  // carry into each bit
    cy_raw  = byte_i ? cin_vec[H] : s[W];
    carry_o = cy_raw ^ sub_i;      // borrow on subtract
    aux_o   = cin_vec[4] ^ sub_i;
    ovf_o   = byte_i ? (cin_vec[H] ^ cin_vec[H-1]) : (s[W] ^ cin_vec[W-1]);
    sum_o   = byte_i ? {{(W-H){1'b0}}, s[H-1:0]} : s[W-1:0];
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 16
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  alu_pkg::alu_op_e op_i,
  input  logic            byte_i,
  output logic [W-1:0]    out_o
);
  import alu_pkg::*;
  localparam int H = W / 2;

  logic [W-1:0] raw;

  always_comb begin
    unique case (op_i)
      OP_AND:  raw = a_i & b_i;
      OP_OR:   raw = a_i | b_i;
      OP_XOR:  raw = a_i ^ b_i;
      default: raw = '0;
    endcase
    out_o = byte_i ? {{(W-H){1'b0}}, raw[H-1:0]} : raw;
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cond_we_i,
  input  logic              keep_cf_i,
  input  cond_flags_t       cond_i,
  input  logic              ctl_we_i,
  input  logic [2:0]        ctl_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else begin
      if (cond_we_i) begin
        if (!keep_cf_i) flags_q[CF_POS] <= cond_i.cf_f;
        flags_q[PF_POS] <= cond_i.pf_f;
        flags_q[AF_POS] <= cond_i.af_f;
        flags_q[ZF_POS] <= cond_i.zf_f;
        flags_q[SF_POS] <= cond_i.sf_f;
        flags_q[OF_POS] <= cond_i.of_f;
      end
      if (ctl_we_i) begin
        flags_q[TF_POS] <= ctl_i[0];
        flags_q[IF_POS] <= ctl_i[1];
        flags_q[DF_POS] <= ctl_i[2];
      end
    end
  end

  assign flags_o = flags_q;

  a_r9_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cond_we_i && !ctl_we_i) |=> $stable(flags_q));

  a_r9_ctl_untouched_by_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i |=> (flags_q[DF_POS:TF_POS] == $past(flags_q[DF_POS:TF_POS])));

  a_r10_ctl_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> (flags_q[DF_POS:TF_POS] == $past(ctl_i)));

  a_r8_cf_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_we_i && keep_cf_i) |=> (flags_q[CF_POS] == $past(flags_q[CF_POS])));

  a_r10_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[1] | flags_q[3] | flags_q[5] | (|flags_q[15:12])) == 1'b0);
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        op_i,
  input  logic              byte_i,
  input  logic              flag_we_i,
  input  logic              ctl_we_i,
  input  logic [2:0]        ctl_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int H = DATA_W / 2;

  alu_op_e           op;
  logic              is_arith, is_logic, is_sub, is_step;
  logic [DATA_W-1:0] as_b, as_sum, lg_out, res;
  logic              as_cy, as_aux, as_ovf;
  cond_flags_t       cond;

  assign op       = alu_op_e'(op_i);
  assign is_step  = (op == OP_INC) || (op == OP_DEC);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB) || is_step;
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign is_sub   = (op == OP_SUB) || (op == OP_DEC);
  assign as_b     = is_step ? DATA_W'(1) : b_i;

  alu_addsub #(.W(DATA_W)) u_addsub (
    .a_i     (a_i),
    .b_i     (as_b),
    .sub_i   (is_sub),
    .byte_i  (byte_i),
    .sum_o   (as_sum),
    .carry_o (as_cy),
    .aux_o   (as_aux),
    .ovf_o   (as_ovf)
  );

  alu_logic #(.W(DATA_W)) u_logic (
    .a_i    (a_i),
    .b_i    (b_i),
    .op_i   (op),
    .byte_i (byte_i),
    .out_o  (lg_out)
  );

  always_comb begin
    if (is_arith)      res = as_sum;
    else if (is_logic) res = lg_out;
    else               res = '0;
    cond.cf_f = is_arith & as_cy;
    cond.af_f = is_arith & as_aux;
    cond.of_f = is_arith & as_ovf;
    cond.pf_f = ~^res[7:0];
    cond.zf_f = (res == '0);
    cond.sf_f = byte_i ? res[H-1] : res[DATA_W-1];
  end

  assign result_o = res;

  alu_flag_reg u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cond_we_i (flag_we_i && (op != OP_RSV)),
    .keep_cf_i (is_step),
    .cond_i    (cond),
    .ctl_we_i  (ctl_we_i),
    .ctl_i     (ctl_i),
    .flags_o   (flags_o)
  );

  a_r5_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i != 3'd7) |=> (flags_o[ZF_POS] == ($past(result_o) == '0)));

  a_r7_logic_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && (op_i == 3'd2 || op_i == 3'd3 || op_i == 3'd4))
      |=> (!flags_o[CF_POS] && !flags_o[OF_POS] && !flags_o[AF_POS]));

  a_r4_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i != 3'd7) |=> (flags_o[PF_POS] == ($countones($past(result_o[7:0])) % 2 == 0)));

  a_r12_reserved_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd7 && !ctl_we_i) |=> $stable(flags_o));

  a_r1_byte_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_i |-> (result_o[DATA_W-1:H] == '0));
endmodule

// File: tb/sim_alu_flag_unit.sv
module sim_alu_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic [2:0]  op = '0;
  logic        byt = 1'b0, fwe = 1'b0, cwe = 1'b0;
  logic [2:0]  ctl = '0;
  logic [15:0] res, flg;
  int          checks = 0, errors = 0;
  logic [15:0] exp_flags = '0;

  always #2 clk = ~clk;

  alu_flag_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .op_i(op), .byte_i(byt),
    .flag_we_i(fwe), .ctl_we_i(cwe), .ctl_i(ctl), .result_o(res), .flags_o(flg)
  );

  // {op, byte, a, b}
  localparam int NV = 18;
  localparam logic [35:0] VEC [NV] = '{
    {3'd0, 1'b0, 16'h0001, 16'hFFFF},
    {3'd0, 1'b0, 16'h7FFF, 16'h0001},
    {3'd0, 1'b0, 16'h8000, 16'h8000},
    {3'd5, 1'b0, 16'h7FFF, 16'h0000},
    {3'd1, 1'b0, 16'h0000, 16'h0001},
    {3'd6, 1'b0, 16'h0000, 16'h0000},
    {3'd1, 1'b0, 16'h8000, 16'h0001},
    {3'd1, 1'b0, 16'h1234, 16'h1234},
    {3'd5, 1'b0, 16'hFFFF, 16'h0000},
    {3'd2, 1'b0, 16'hF0F0, 16'h0FF0},
    {3'd3, 1'b0, 16'h1200, 16'h0034},
    {3'd4, 1'b0, 16'hAAAA, 16'hAAAA},
    {3'd0, 1'b1, 16'h12FF, 16'h0001},
    {3'd6, 1'b1, 16'hFF00, 16'h0000},
    {3'd1, 1'b1, 16'h0080, 16'h0001},
    {3'd5, 1'b1, 16'h007F, 16'h0000},
    {3'd4, 1'b1, 16'h80F0, 16'h000F},
    {3'd0, 1'b1, 16'hFF08, 16'h8008}
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s: got %h expected %h (t=%0t)", req, got, expv, $time);
    end
  endtask

  function automatic int sx(input logic [15:0] v, input logic bm);
    if (bm) return int'($signed(v[7:0]));
    return int'($signed(v));
  endfunction

  // Behavioural model: returns {flags, result}
  function automatic logic [31:0] model(input logic [2:0] o, input logic bm,
                                        input logic [15:0] x, input logic [15:0] y,
                                        input logic [15:0] old);
    int unsigned msk = bm ? 32'hFF : 32'hFFFF;
    int unsigned ux = x & msk, uy = y & msk;
    int smin = bm ? -128 : -32768, smax = bm ? 127 : 32767, sr;
    logic [15:0] r, f;
    logic c, ac, ov;
    f = old;
    c = 1'b0; ac = 1'b0; ov = 1'b0;
    if (o == 3'd5 || o == 3'd6) uy = 1;
    case (o)
      3'd0, 3'd5: begin
        r  = 16'(ux + uy) & 16'(msk);
        c  = (ux + uy) > msk;
        ac = ((ux & 15) + (uy & 15)) > 15;
        sr = sx(x, bm) + int'(uy);
        if (o == 3'd0) sr = sx(x, bm) + sx(y, bm);
        ov = (sr > smax) || (sr < smin);
      end
      3'd1, 3'd6: begin
        r  = 16'(ux - uy) & 16'(msk);
        c  = ux < uy;
        ac = (ux & 15) < (uy & 15);
        sr = sx(x, bm) - int'(uy);
        if (o == 3'd1) sr = sx(x, bm) - sx(y, bm);
        ov = (sr > smax) || (sr < smin);
      end
      3'd2: r = 16'(ux & uy);
      3'd3: r = 16'(ux | uy);
      3'd4: r = 16'(ux ^ uy);
      default: r = '0;
    endcase
    if (o != 3'd7) begin
      if (!(o == 3'd5 || o == 3'd6)) f[0] = c;
      f[4]  = ac;
      f[11] = ov;
      f[2]  = ~^r[7:0];
      f[6]  = (r == 0);
      f[7]  = bm ? r[7] : r[15];
    end
    return {f, r};
  endfunction

  task automatic run_op(input logic [2:0] o, input logic bm, input logic [15:0] x,
                        input logic [15:0] y, input logic we);
    logic [31:0] m;
    string cf_req;
    @(negedge clk);
    op = o; byt = bm; a = x; b = y; fwe = we;
    m = model(o, bm, x, y, exp_flags);
    #1;
    if (o == 3'd7) check("R12 result", res, 16'h0);
    else           check("R1 result", res, m[15:0]);
    @(posedge clk);
    @(negedge clk);
    fwe = 1'b0;
    if (we) exp_flags = m[31:16];
    if (o == 3'd5 || o == 3'd6) cf_req = "R8 CF";
    else if (o >= 3'd2 && o <= 3'd4) cf_req = "R7 CF";
    else cf_req = "R2 CF";
    check(cf_req,     {15'd0, flg[0]},  {15'd0, exp_flags[0]});
    check("R3 AF",    {15'd0, flg[4]},  {15'd0, exp_flags[4]});
    check("R4 PF",    {15'd0, flg[2]},  {15'd0, exp_flags[2]});
    check("R5 ZF",    {15'd0, flg[6]},  {15'd0, exp_flags[6]});
    check("R5 SF",    {15'd0, flg[7]},  {15'd0, exp_flags[7]});
    check("R6 OF",    {15'd0, flg[11]}, {15'd0, exp_flags[11]});
    check("R9 word",  flg, exp_flags);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset", flg, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      run_op(VEC[i][35:33], VEC[i][32], VEC[i][31:16], VEC[i][15:0], 1'b1);

    // R9: no write enable, flags hold
    run_op(3'd0, 1'b0, 16'hFFFF, 16'h0001, 1'b1);
    run_op(3'd2, 1'b0, 16'h0001, 16'h0001, 1'b0);

    // R10: control flag load alongside condition update
    @(negedge clk);
    ctl = 3'b101; cwe = 1'b1;
    @(negedge clk);
    cwe = 1'b0;
    exp_flags[10:8] = 3'b101;
    check("R10 ctl load", flg, exp_flags);
    run_op(3'd4, 1'b0, 16'h00FF, 16'h0F0F, 1'b1);
    check("R9 ctl kept", {13'd0, flg[10:8]}, 16'd5);
    @(negedge clk);
    ctl = 3'b010; cwe = 1'b1;
    @(negedge clk);
    cwe = 1'b0;
    exp_flags[10:8] = 3'b010;
    check("R10 ctl reload", flg, exp_flags);
    check("R10 unused zero", flg & 16'hF02A, 16'h0000);

    // R8: carry set then increment keeps it
    run_op(3'd1, 1'b0, 16'h0000, 16'h0005, 1'b1);
    run_op(3'd5, 1'b0, 16'h000F, 16'h0000, 1'b1);
    check("R8 CF kept", {15'd0, flg[0]}, 16'd1);

    // R12: reserved code leaves flags alone
    run_op(3'd7, 1'b0, 16'h1234, 16'h5678, 1'b1);

    // R11: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 async clear", flg, 16'h0000);
    exp_flags = '0;
    @(negedge clk);
    rst_n = 1'b1;
    run_op(3'd0, 1'b1, 16'h0040, 16'h0040, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule